// File: doc/BRIEF.md
# Inter-Access Idle Cycle Scheduler

This block decides when the next access of a multi-chip-select external memory controller may start. It remembers the chip select and the direction (read or write) of the access that last ran on the bus. When that access signals that its chip-select deassertion has finished, the block starts counting idle cycles. A pending access is offered through a valid/ready handshake. It is granted only once the required gap has passed.

The required gap is the larger of two delays that count at the same time. The first is a turnaround delay. It belongs to the access that is ending and applies only after a read. The second is a cycle-to-cycle delay. It belongs to the access that is starting and is enabled separately for a repeat of the same chip select and for a switch to another chip select. While a pending access is held back, a hold indicator tells the strobe logic to keep every bus control strobe inactive.

Top module: `idle_gap_sched`

## Requirements
- R1: After reset no previous access is recorded, so the first request is granted in the cycle it is presented, whatever the configuration, and hold_idle stays low.
- R2: Only one access is in flight. After a grant, req_ready stays low until access_done is pulsed.
- R3: When the starting chip select equals the previous one and its same-select enable is set, the gap is at least its 4-bit cycle-to-cycle count.
- R4: When the starting chip select differs from the previous one and the starting select's different-select enable is set, the gap is at least the starting select's 4-bit cycle-to-cycle count.
- R5: The ending select's 4-bit turnaround count applies only when the previous access was a read (req_rd = 1) and the count is nonzero, and at least one of these holds: the new access is a write (req_rd = 0); either select has its multiplexed flag set; the new access is a read to a different select.
- R6: A read after a read on the same select, with neither multiplexed flag set, inserts no turnaround cycles, even with a nonzero turnaround count.
- R7: When both delays apply, the gap is the maximum of the two, not their sum.
- R8: When neither delay applies (previous access a write or turnaround count zero, and the relevant enable clear, or a count of zero), the next request is granted in the first cycle after access_done.
- R9: The gap is counted from the clock edge that samples access_done. With a gap of G cycles, req_ready rises exactly G cycles after the first cycle following that edge.
- R10: hold_idle is high exactly while a request is pending, no access is in flight and the gap has not yet elapsed. hold_idle and req_ready are never high together.
- R11: An access_done pulse while no access is in flight is ignored and does not restart the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_c2c_delay | input | NUM_CS*CNT_W | Cycle-to-cycle count per select, select i at bits [i*CNT_W +: CNT_W] |
| cfg_same_en | input | NUM_CS | Per select: enable the delay on a repeat of the same select |
| cfg_diff_en | input | NUM_CS | Per select: enable the delay after another select |
| cfg_turn | input | NUM_CS*CNT_W | Turnaround count per select, same packing |
| cfg_muxed | input | NUM_CS | Per select: address/data multiplexed bus |
| req_valid | input | 1 | Pending access present |
| req_cs | input | CS_W | Chip select of the pending access |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_ready | output | 1 | Start grant; the access starts on a clock edge with valid and ready both high |
| access_done | input | 1 | One-cycle pulse: the in-flight access finished its chip-select deassertion |
| hold_idle | output | 1 | Pending access held back; strobes must stay inactive |

## Verification
The bench sweeps pairs of accesses over same and different selects, all four read/write orderings, and multiplexed versus plain buses. These are crossed with turnaround counts of zero and nonzero, cycle-to-cycle counts of 0, 2 and 5, and both enables. For each pair it measures the idle cycles between access_done and the grant and compares them with a gap computed from the rules. This separates turnaround-only, cycle-to-cycle-only, overlapping (maximum, not sum) and no-gap cases, and it isolates the read-after-read same-select exemption. Separate cases cover the first access after reset, the block on a second grant while an access is in flight, and a stray access_done that must not restart the count.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

    typedef enum logic {
        ACC_WR = 1'b0,
        ACC_RD = 1'b1
    } acc_kind_e;

    function automatic logic [7:0] umax8(input logic [7:0] a, input logic [7:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/idle_gap_cfg_sel.sv
module idle_gap_cfg_sel #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic [NUM_CS*CNT_W-1:0] cfg_c2c_delay,
    input  logic [NUM_CS-1:0]       cfg_same_en,
    input  logic [NUM_CS-1:0]       cfg_diff_en,
    input  logic [NUM_CS*CNT_W-1:0] cfg_turn,
    input  logic [NUM_CS-1:0]       cfg_muxed,
    input  logic [CS_W-1:0]         end_sel,
    input  logic [CS_W-1:0]         start_sel,
    output logic [CNT_W-1:0]        end_turn,
    output logic                    end_muxed,
    output logic [CNT_W-1:0]        start_c2c,
    output logic                    start_muxed,
    output logic                    start_same_en,
    output logic                    start_diff_en
);

    logic [CNT_W-1:0] c2c_arr  [NUM_CS];
    logic [CNT_W-1:0] turn_arr [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
        assign c2c_arr[i]  = cfg_c2c_delay[i*CNT_W +: CNT_W];
        assign turn_arr[i] = cfg_turn[i*CNT_W +: CNT_W];
    end

    assign end_turn      = turn_arr[end_sel];
    assign end_muxed     = cfg_muxed[end_sel];
    assign start_c2c     = c2c_arr[start_sel];
    assign start_muxed   = cfg_muxed[start_sel];
    assign start_same_en = cfg_same_en[start_sel];
    assign start_diff_en = cfg_diff_en[start_sel];

endmodule

// File: rtl/idle_gap_calc.sv
module idle_gap_calc
    import idle_gap_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             prev_valid,
    input  acc_kind_e        prev_kind,
    input  acc_kind_e        next_kind,
    input  logic             same_sel,
    input  logic             any_muxed,
    input  logic [CNT_W-1:0] turn_cnt,
    input  logic [CNT_W-1:0] c2c_cnt,
    input  logic             same_en,
    input  logic             diff_en,
    output logic [CNT_W-1:0] gap
);

    logic             turn_on;
    logic             c2c_on;
    logic [CNT_W-1:0] turn_part;
    logic [CNT_W-1:0] c2c_part;
    logic [7:0]       wide_max;

    always_comb begin
        // turnaround: owned by the ending read, only for bus-direction or select changes
        turn_on   = (prev_kind == ACC_RD) && (turn_cnt != '0) &&
                    ((next_kind == ACC_WR) || any_muxed || !same_sel);
        // cycle-to-cycle: owned by the starting select
        c2c_on    = same_sel ? same_en : diff_en;
        turn_part = turn_on ? turn_cnt : '0;
        c2c_part  = c2c_on  ? c2c_cnt  : '0;
        wide_max  = umax8(8'(turn_part), 8'(c2c_part));
        gap       = prev_valid ? wide_max[CNT_W-1:0] : '0;
    end

endmodule

// File: rtl/idle_gap_sched.sv
module idle_gap_sched
    import idle_gap_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CS*CNT_W-1:0] cfg_c2c_delay,
    input  logic [NUM_CS-1:0]       cfg_same_en,
    input  logic [NUM_CS-1:0]       cfg_diff_en,
    input  logic [NUM_CS*CNT_W-1:0] cfg_turn,
    input  logic [NUM_CS-1:0]       cfg_muxed,
    input  logic                    req_valid,
    input  logic [CS_W-1:0]         req_cs,
    input  logic                    req_rd,
    output logic                    req_ready,
    input  logic                    access_done,
    output logic                    hold_idle
);

    typedef struct packed {
        logic             busy;
        logic             last_valid;
        logic [CS_W-1:0]  last_cs;
        acc_kind_e        last_kind;
        logic [CNT_W-1:0] elapsed;
    } sched_t;

    sched_t st_q, st_d;

    logic [CNT_W-1:0] end_turn, start_c2c, gap;
    logic             end_muxed, start_muxed, start_same_en, start_diff_en;
    logic             gap_met;
    acc_kind_e        req_kind;

    assign req_kind = req_rd ? ACC_RD : ACC_WR;

    idle_gap_cfg_sel #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) cfg_sel_i (
        .cfg_c2c_delay (cfg_c2c_delay),
        .cfg_same_en   (cfg_same_en),
        .cfg_diff_en   (cfg_diff_en),
        .cfg_turn      (cfg_turn),
        .cfg_muxed     (cfg_muxed),
        .end_sel       (st_q.last_cs),
        .start_sel     (req_cs),
        .end_turn      (end_turn),
        .end_muxed     (end_muxed),
        .start_c2c     (start_c2c),
        .start_muxed   (start_muxed),
        .start_same_en (start_same_en),
        .start_diff_en (start_diff_en)
    );

    idle_gap_calc #(.CNT_W(CNT_W)) calc_i (
        .prev_valid (st_q.last_valid),
        .prev_kind  (st_q.last_kind),
        .next_kind  (req_kind),
        .same_sel   (st_q.last_cs == req_cs),
        .any_muxed  (end_muxed | start_muxed),
        .turn_cnt   (end_turn),
        .c2c_cnt    (start_c2c),
        .same_en    (start_same_en),
        .diff_en    (start_diff_en),
        .gap        (gap)
    );

    always_comb begin
        st_d      = st_q;
        gap_met   = !st_q.last_valid || (st_q.elapsed >= gap);
        req_ready = req_valid && !st_q.busy && gap_met;
        hold_idle = req_valid && !st_q.busy && !gap_met;

        if (!st_q.busy && (st_q.elapsed != '1)) begin
            st_d.elapsed = st_q.elapsed + 1'b1;
        end

        if (req_ready) begin
            st_d.busy      = 1'b1;
            st_d.last_cs   = req_cs;
            st_d.last_kind = req_kind;
        end else if (st_q.busy && access_done) begin
            st_d.busy       = 1'b0;
            st_d.last_valid = 1'b1;
            st_d.elapsed    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy       <= 1'b0;
            st_q.last_valid <= 1'b0;
            st_q.last_cs    <= '0;
            st_q.last_kind  <= ACC_WR;
            st_q.elapsed    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/idle_gap_sched_chk.sv
module idle_gap_sched_chk #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CS*CNT_W-1:0] cfg_c2c_delay,
    input logic [NUM_CS-1:0]       cfg_same_en,
    input logic [NUM_CS-1:0]       cfg_diff_en,
    input logic                    req_valid,
    input logic [CS_W-1:0]         req_cs,
    input logic                    req_ready,
    input logic                    access_done,
    input logic                    hold_idle
);

    logic             in_flight, seen_done, seen_any;
    logic [CS_W-1:0]  prev_cs;
    logic [CNT_W-1:0] since_done;
    logic             grant;
    logic [CNT_W-1:0] req_c2c;

    assign grant   = req_valid && req_ready;
    assign req_c2c = cfg_c2c_delay[req_cs*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight  <= 1'b0;
            seen_done  <= 1'b0;
            seen_any   <= 1'b0;
            prev_cs    <= '0;
            since_done <= '1;
        end else begin
            if (grant) begin
                in_flight <= 1'b1;
                seen_any  <= 1'b1;
                prev_cs   <= req_cs;
            end else if (in_flight && access_done) begin
                in_flight <= 1'b0;
                seen_done <= 1'b1;
            end
            if (in_flight && access_done) since_done <= '0;
            else if (since_done != '1)    since_done <= since_done + 1'b1;
        end
    end

    a_r1_first_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_any && req_valid) |-> req_ready);

    a_r2_single_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight |-> !req_ready);

    a_r3_same_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && seen_done && (req_cs == prev_cs) && cfg_same_en[req_cs])
        |-> (since_done >= req_c2c));

    a_r4_diff_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && seen_done && (req_cs != prev_cs) && cfg_diff_en[req_cs])
        |-> (since_done >= req_c2c));

    a_r10_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_idle && req_ready));

endmodule

bind idle_gap_sched idle_gap_sched_chk #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_c2c_delay (cfg_c2c_delay),
    .cfg_same_en   (cfg_same_en),
    .cfg_diff_en   (cfg_diff_en),
    .req_valid     (req_valid),
    .req_cs        (req_cs),
    .req_ready     (req_ready),
    .access_done   (access_done),
    .hold_idle     (hold_idle)
);

// File: tb/idle_gap_sched_tb_top.sv
`timescale 1ns/1ps
module idle_gap_sched_tb_top;

    localparam int NUM_CS = 4;
    localparam int CNT_W  = 4;
    localparam int CS_W   = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CS*CNT_W-1:0] cfg_c2c_delay = '0;
    logic [NUM_CS-1:0]       cfg_same_en = '0;
    logic [NUM_CS-1:0]       cfg_diff_en = '0;
    logic [NUM_CS*CNT_W-1:0] cfg_turn = '0;
    logic [NUM_CS-1:0]       cfg_muxed = '0;
    logic                    req_valid = 1'b0;
    logic [CS_W-1:0]         req_cs = '0;
    logic                    req_rd = 1'b0;
    logic                    req_ready;
    logic                    access_done = 1'b0;
    logic                    hold_idle;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    idle_gap_sched #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_c2c_delay(cfg_c2c_delay), .cfg_same_en(cfg_same_en),
        .cfg_diff_en(cfg_diff_en), .cfg_turn(cfg_turn), .cfg_muxed(cfg_muxed),
        .req_valid(req_valid), .req_cs(req_cs), .req_rd(req_rd),
        .req_ready(req_ready), .access_done(access_done), .hold_idle(hold_idle)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_all(input int c2c, input bit s_en, input bit d_en,
                           input int turn, input bit mux);
        for (int i = 0; i < NUM_CS; i++) begin
            cfg_c2c_delay[i*CNT_W +: CNT_W] = CNT_W'(c2c);
            cfg_turn[i*CNT_W +: CNT_W]      = CNT_W'(turn);
        end
        cfg_same_en = {NUM_CS{s_en}};
        cfg_diff_en = {NUM_CS{d_en}};
        cfg_muxed   = {NUM_CS{mux}};
    endtask

    // Called at a negedge. Presents a request, counts the idle cycles until
    // it is granted, checks the in-flight block, then finishes the access.
    task automatic run_access(input int cs, input bit rd, output int waited,
                              output bit idle_first, output bit idle_at_grant);
        req_cs = CS_W'(cs);
        req_rd = rd;
        req_valid = 1'b1;
        waited = 0;
        #1;
        idle_first = hold_idle;
        while (!req_ready && waited < 40) begin
            @(negedge clk);
            #1;
            waited++;
        end
        idle_at_grant = hold_idle;
        @(negedge clk);
        #1;
        check(!req_ready, "R2 ready during in-flight access", int'(req_ready), 0);
        access_done = 1'b1;
        @(negedge clk);
        access_done = 1'b0;
        req_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int  w;
        bit  i0, i1;
        set_all(5, 1'b1, 1'b1, 7, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: first access after reset granted immediately
        req_cs = 2'd2; req_rd = 1'b1; req_valid = 1'b1;
        #1;
        check(req_ready == 1'b1, "R1 first request ready", int'(req_ready), 1);
        check(hold_idle == 1'b0, "R1 no hold after reset", int'(hold_idle), 0);
        req_valid = 1'b0;
        @(negedge clk);

        // Exhaustive sweep of access pairs
        for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
        for (int ra = 0; ra < 2; ra++)
        for (int rb = 0; rb < 2; rb++)
        for (int mx = 0; mx < 2; mx++)
        for (int tv = 0; tv < 2; tv++)
        for (int cv = 0; cv < 3; cv++)
        for (int se = 0; se < 2; se++)
        for (int de = 0; de < 2; de++) begin
            int    turn, c2c, g, tpart, cpart;
            bit    same, t_on, c_on;
            string tag;
            turn = tv ? 3 : 0;
            c2c  = (cv == 0) ? 0 : (cv == 1) ? 2 : 5;
            set_all(c2c, bit'(se), bit'(de), turn, bit'(mx));
            same  = (a == b);
            t_on  = (ra == 1) && (turn != 0) && (rb == 0 || mx == 1 || !same);
            c_on  = same ? bit'(se) : bit'(de);
            tpart = t_on ? turn : 0;
            cpart = c_on ? c2c : 0;
            g     = (tpart > cpart) ? tpart : cpart;
            if (ra == 1 && rb == 1 && same && mx == 0 && turn != 0 && !c_on) tag = "R9 R6";
            else if (t_on && c_on && c2c != 0) tag = "R9 R7";
            else if (t_on)                     tag = "R9 R5";
            else if (c_on && c2c != 0)         tag = same ? "R9 R3" : "R9 R4";
            else                               tag = "R9 R8";
            run_access(a, bit'(ra), w, i0, i1);
            run_access(b, bit'(rb), w, i0, i1);
            check(w == g, tag, w, g);
            check(i0 == (g > 0), "R10 hold while gap pending", int'(i0), int'(g > 0));
            check(i1 == 1'b0, "R10 hold low at grant", int'(i1), 0);
        end

        // R11: stray done after the gap expired must not restart it
        set_all(5, 1'b1, 1'b1, 0, 1'b0);
        run_access(0, 1'b0, w, i0, i1);
        repeat (20) @(negedge clk);
        access_done = 1'b1;
        @(negedge clk);
        access_done = 1'b0;
        req_cs = 2'd1; req_rd = 1'b0; req_valid = 1'b1;
        #1;
        check(req_ready == 1'b1, "R11 stray done ignored", int'(req_ready), 1);
        check(hold_idle == 1'b0, "R11 no hold after stray done", int'(hold_idle), 0);
        req_valid = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule